// File: doc/BRIEF.md
# Serial Divider Configuration Port

This block receives configuration words for a frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load-enable line. All three lines are synchronised into one system clock, and edges are detected there, so the whole block runs on a single clock. Bits are shifted into a 19-bit frame register on each rising edge of the serial clock, most significant bit first.

When load-enable rises, the frame register is copied into one of two holding latches. The last bit shifted in selects the latch. The feedback latch holds a swallow count and a main count for the feedback divider. The reference latch holds a reference count and four option bits: prescaler modulus, detector polarity, monitor-pin select and pump current. The latched fields are presented in parallel. The latch that was written raises a one-cycle update pulse. A load that arrives before a full frame has been shifted still copies whatever the frame register holds at that moment, and no error is flagged.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset the swallow count is 0, the main count is 3, the reference count is 3, all four option outputs are 0 and both update pulses are low.
- R2: Each rising edge of the serial clock taken while load-enable is low shifts the data line into the frame register, most significant bit first. After 19 such edges, the first bit sent sits at frame position 19 and the last bit sent sits at position 1.
- R3: A load with frame position 1 equal to 0 writes the feedback latch. Positions 8..2 become the swallow count, with position 2 as its LSB. Positions 19..9 become the main count, with position 9 as its LSB.
- R4: A load with frame position 1 equal to 1 writes the reference latch. Positions 15..2 become the reference count, with position 2 as its LSB. Position 16 drives mod_sel_o (1 = 32/33 modulus, 0 = 64/65). Position 17 drives pd_pol_o. Position 18 drives mon_sel_o (1 = divided-frequency monitor, 0 = lock signal). Position 19 drives pump_hi_o (1 = high current).
- R5: Each rising edge of load-enable raises exactly one update pulse, for the latch written, for exactly one system clock cycle. The two pulses are never high together.
- R6: A load into one latch leaves every output field of the other latch unchanged.
- R7: A load after fewer than 19 shifted bits copies the current frame register. Its higher positions still hold the older bits, moved up by the number of new bits.
- R8: The latched outputs change only in the cycle in which the matching update pulse is high. Shifting a frame without a load leaves them unchanged.
- R9: Serial clock edges that occur while load-enable is high do not shift. A second load then copies the same frame again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_le_i | input | 1 | Load-enable, asynchronous |
| swallow_o | output | 7 | Latched swallow count |
| main_o | output | 11 | Latched main count |
| ref_div_o | output | 14 | Latched reference count |
| mod_sel_o | output | 1 | Prescaler modulus select, 1 = 32/33 |
| pd_pol_o | output | 1 | Phase detector polarity |
| mon_sel_o | output | 1 | Multifunction pin select, 1 = frequency monitor |
| pump_hi_o | output | 1 | Pump current select, 1 = high |
| fb_upd_o | output | 1 | One-cycle pulse on a feedback latch write |
| ref_upd_o | output | 1 | One-cycle pulse on a reference latch write |

## Verification
The assertions check several properties on every cycle. The two update pulses must be mutually exclusive and one cycle wide. Each latch's outputs may change only while that latch's pulse is high, so a write to one latch can never disturb the other.

Other behaviour can only be shown by the bench's scenarios. These are that fields land at the right bit positions for both frame formats, that a short frame keeps the older bits, and that clock edges taken while load-enable is high are ignored. The bench compares the outputs against a bit-level model of the shift register after directed and random frames.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
    localparam int A_W     = 7;
    localparam int N_W     = 11;
    localparam int R_W     = 14;
    localparam int OPT_W   = 4;
    localparam int FRAME_W = 1 + A_W + N_W;
    localparam int BODY_W  = FRAME_W - 1;

    // option field order is decoded by the synthesizer core: pump MSB
    typedef struct packed {
        logic pump_hi;
        logic mon_sel;
        logic pd_pol;
        logic mod_sel;
    } opt_t;

    typedef struct packed {
        logic [N_W-1:0] main_cnt;
        logic [A_W-1:0] swallow;
    } fb_word_t;

    typedef struct packed {
        opt_t           opt;
        logic [R_W-1:0] ref_cnt;
    } ref_word_t;

    localparam fb_word_t  FB_RST  = '{main_cnt: N_W'(3), swallow: '0};
    localparam ref_word_t REF_RST = '{opt: '0, ref_cnt: R_W'(3)};
endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/frame_shift.sv
module frame_shift
    import cfg_port_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_i,
    input  logic               sdat_i,
    input  logic               le_i,
    output logic [FRAME_W-1:0] frame_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic               sclk_prev;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      shift_en;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_i;
        shift_en       = sclk_i & ~st_q.sclk_prev & ~le_i;
        if (shift_en) begin
            st_d.sr = {st_q.sr[FRAME_W-2:0], sdat_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_o = st_q.sr;
endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
    import cfg_port_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               le_i,
    input  logic [FRAME_W-1:0] frame_i,
    output fb_word_t           fb_o,
    output ref_word_t          ref_o,
    output logic               fb_upd_o,
    output logic               ref_upd_o
);
    typedef struct packed {
        fb_word_t  fb;
        ref_word_t rf;
        logic      fb_upd;
        logic      ref_upd;
        logic      le_prev;
    } latch_st_t;

    localparam latch_st_t ST_RST = '{fb: FB_RST, rf: REF_RST,
                                     fb_upd: 1'b0, ref_upd: 1'b0, le_prev: 1'b0};

    latch_st_t st_d, st_q;
    logic      load;

    always_comb begin
        st_d         = st_q;
        st_d.le_prev = le_i;
        st_d.fb_upd  = 1'b0;
        st_d.ref_upd = 1'b0;
        load         = le_i & ~st_q.le_prev;
        if (load) begin
            if (frame_i[0]) begin
                st_d.rf      = ref_word_t'(frame_i[FRAME_W-1:1]);
                st_d.ref_upd = 1'b1;
            end else begin
                st_d.fb      = fb_word_t'(frame_i[FRAME_W-1:1]);
                st_d.fb_upd  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign fb_o      = st_q.fb;
    assign ref_o     = st_q.rf;
    assign fb_upd_o  = st_q.fb_upd;
    assign ref_upd_o = st_q.ref_upd;
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import cfg_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk_i,
    input  logic           ser_dat_i,
    input  logic           ser_le_i,
    output logic [A_W-1:0] swallow_o,
    output logic [N_W-1:0] main_o,
    output logic [R_W-1:0] ref_div_o,
    output logic           mod_sel_o,
    output logic           pd_pol_o,
    output logic           mon_sel_o,
    output logic           pump_hi_o,
    output logic           fb_upd_o,
    output logic           ref_upd_o
);
    localparam int LANES = 3;
    localparam int L_CLK = 0;
    localparam int L_DAT = 1;
    localparam int L_LE  = 2;

    logic [LANES-1:0]   lines_s;
    logic [FRAME_W-1:0] frame;
    fb_word_t           fb_w;
    ref_word_t          ref_w;

    line_sync #(.W(LANES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_le_i, ser_dat_i, ser_clk_i}),
        .sync_o  (lines_s)
    );

    frame_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (lines_s[L_CLK]),
        .sdat_i  (lines_s[L_DAT]),
        .le_i    (lines_s[L_LE]),
        .frame_o (frame)
    );

    cfg_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .le_i      (lines_s[L_LE]),
        .frame_i   (frame),
        .fb_o      (fb_w),
        .ref_o     (ref_w),
        .fb_upd_o  (fb_upd_o),
        .ref_upd_o (ref_upd_o)
    );

    assign swallow_o = fb_w.swallow;
    assign main_o    = fb_w.main_cnt;
    assign ref_div_o = ref_w.ref_cnt;
    assign mod_sel_o = ref_w.opt.mod_sel;
    assign pd_pol_o  = ref_w.opt.pd_pol;
    assign mon_sel_o = ref_w.opt.mon_sel;
    assign pump_hi_o = ref_w.opt.pump_hi;
endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk
    import cfg_port_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [A_W-1:0] swallow_o,
    input logic [N_W-1:0] main_o,
    input logic [R_W-1:0] ref_div_o,
    input logic           mod_sel_o,
    input logic           pd_pol_o,
    input logic           mon_sel_o,
    input logic           pump_hi_o,
    input logic           fb_upd_o,
    input logic           ref_upd_o
);
    assert_pulse_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fb_upd_o, ref_upd_o}));

    assert_fb_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fb_upd_o |=> !fb_upd_o);

    assert_ref_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_upd_o |=> !ref_upd_o);

    // R6 and R8: feedback fields move only with their own pulse
    assert_fb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_upd_o |-> ($stable(swallow_o) && $stable(main_o)));

    // R6 and R8: reference fields move only with their own pulse
    assert_ref_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_upd_o |-> ($stable(ref_div_o) &&
                        $stable({pump_hi_o, mon_sel_o, pd_pol_o, mod_sel_o})));
endmodule

bind serial_cfg_port serial_cfg_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .swallow_o (swallow_o),
    .main_o    (main_o),
    .ref_div_o (ref_div_o),
    .mod_sel_o (mod_sel_o),
    .pd_pol_o  (pd_pol_o),
    .mon_sel_o (mon_sel_o),
    .pump_hi_o (pump_hi_o),
    .fb_upd_o  (fb_upd_o),
    .ref_upd_o (ref_upd_o)
);

// File: tb/sim_serial_cfg_port.sv
`timescale 1ns/1ps
module sim_serial_cfg_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
    logic [6:0]  swallow;
    logic [10:0] main_c;
    logic [13:0] ref_c;
    logic mod_sel, pd_pol, mon_sel, pump_hi, fb_upd, ref_upd;

    int checks = 0, errors = 0;
    int fb_cnt = 0, ref_cnt = 0;
    bit done = 0;

    logic [18:0] m_sr = '0;
    logic [6:0]  e_a = 7'd0;
    logic [10:0] e_n = 11'd3;
    logic [13:0] e_r = 14'd3;
    logic [3:0]  e_opt = 4'd0;  // {pump, mon, pol, mod}

    always #10 clk = ~clk;

    serial_cfg_port u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
        .ser_le_i(ser_le), .swallow_o(swallow), .main_o(main_c),
        .ref_div_o(ref_c), .mod_sel_o(mod_sel), .pd_pol_o(pd_pol),
        .mon_sel_o(mon_sel), .pump_hi_o(pump_hi), .fb_upd_o(fb_upd),
        .ref_upd_o(ref_upd)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            fb_cnt  <= fb_cnt + int'(fb_upd);
            ref_cnt <= ref_cnt + int'(ref_upd);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_outputs(input string tag);
        chk({tag, " swallow"}, 32'(swallow), 32'(e_a));
        chk({tag, " main"},    32'(main_c),  32'(e_n));
        chk({tag, " ref"},     32'(ref_c),   32'(e_r));
        chk({tag, " opts"},    32'({pump_hi, mon_sel, pd_pol, mod_sel}), 32'(e_opt));
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [18:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = w[i];
            wait_clk(4);
            ser_clk = 1'b1;
            if (!ser_le) m_sr = {m_sr[17:0], w[i]};
            wait_clk(4);
            ser_clk = 1'b0;
        end
        wait_clk(4);
    endtask

    // model of a load: field positions follow R3 and R4
    task automatic model_load();
        if (m_sr[0]) begin
            e_r   = m_sr[14:1];
            e_opt = {m_sr[18], m_sr[17], m_sr[16], m_sr[15]};
        end else begin
            e_a = m_sr[7:1];
            e_n = m_sr[18:8];
        end
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        model_load();
        wait_clk(6);
        ser_le = 1'b0;
        wait_clk(8);
    endtask

    task automatic frame_check(input logic [18:0] w, input string tag);
        int f0, r0;
        f0 = fb_cnt; r0 = ref_cnt;
        send_bits(w, 19);
        pulse_le();
        chk_outputs(tag);
        chk({tag, " R5 fb pulses"},  32'(fb_cnt - f0),  32'(w[0] ? 0 : 1));
        chk({tag, " R5 ref pulses"}, 32'(ref_cnt - r0), 32'(w[0] ? 1 : 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7717));
        wait_clk(5);
        chk_outputs("R1 reset");
        chk("R1 fb pulse", 32'(fb_upd), 32'd0);
        chk("R1 ref pulse", 32'(ref_upd), 32'd0);
        rst_n = 1'b1;
        wait_clk(5);
        chk_outputs("R1 after release");

        // directed feedback frames (R2, R3): N=100, A=5 ; then all ones
        frame_check({11'd100, 7'd5, 1'b0}, "R3 small");
        frame_check({11'h7FF, 7'h7F, 1'b0}, "R3 max");
        // directed reference frames (R4, R6): pump=1 mon=0 pol=1 mod=0
        frame_check({4'b1010, 14'd16383, 1'b1}, "R4 max opt1010");
        frame_check({4'b0101, 14'd3, 1'b1}, "R4 min opt0101");
        chk("R6 fb kept swallow", 32'(swallow), 32'h7F);
        frame_check({11'd3, 7'd0, 1'b0}, "R6 fb min");
        chk("R6 ref kept", 32'(ref_c), 32'd3);

        // R8: partial frame without load leaves outputs unchanged
        send_bits(19'h5A5A5, 10);
        chk_outputs("R8 no load");

        // R7: short frame of 5 bits, select 1
        send_bits(19'h00013, 5);
        pulse_le();
        chk_outputs("R7 short frame");

        // R9: clock edges while load-enable high are ignored
        frame_check({11'd77, 7'd9, 1'b0}, "R2 setup");
        begin
            int f0;
            ser_le = 1'b1;
            wait_clk(8);
            f0 = fb_cnt;
            send_bits(19'h7FFFF, 6);
            ser_le = 1'b0;
            wait_clk(8);
            pulse_le();
            chk_outputs("R9 ignored edges");
            chk("R9 second load pulse", 32'(fb_cnt - f0), 32'd1);
        end

        // random frames
        for (int k = 0; k < 24; k++) begin
            logic [18:0] w;
            w = 19'($urandom());
            frame_check(w, "R2 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule